// File: doc/BRIEF.md
# External Bus Idle Cycle Inserter

This block sits between the access sequencer of an external bus controller and the memory pins. When an access ends, the sequencer pulses `acc_done` and presents what it knows about the access that just finished and the one that will follow: direction, chip select, memory type and whether the next access is a DMA transfer. In the same cycle the block works out how many idle clocks the bus must stay quiet, loads that number into a down-counter, and holds `ready` low until the counter has run out. A pending request for the next access is granted only while `ready` is high.

The idle count comes from four requirements that are evaluated in parallel, and the largest one wins. The first requirement is the programmed gap. It is either one common DMA setting or one of five per-chip-select transition fields. The second requirement is a memory-timing wait. It is either a fixed wait-mode penalty or one of three 2-bit timing fields. The third requirement is the sum of three delays that happen one after another: read data return, internal bus idle and write data wait. The fourth requirement is a penalty that applies only when the memory type changes between the two accesses. The other three requirements can all be zero, so the programmed gap is what sets a guaranteed minimum.

Top module: `bus_idle_gap`

## Requirements
- R1: When `acc_done` is high, the idle count loaded is the largest of four group values G1, G2, G3 and G4.
- R2: G1 is taken from `dma_idle_code` when `next_dma` is 1. Otherwise it is taken from a 3-bit field of the previous chip select: `cs_idle_cfg[prev_cs*15 + f*3 +: 3]`. The field index f depends on the transition. f=0 when the previous access is a write (with any next access). When the previous access is a read: f=1 for a write to another chip select, f=2 for a write to the same chip select, f=3 for a read from another chip select, and f=4 for a read from the same chip select.
- R3: Every 3-bit idle code maps to a cycle count. Codes 0 to 4 give 0 to 4 cycles, and codes 5, 6 and 7 give 6, 8 and 10 cycles.
- R4: G2 is `WM_IDLE` cycles (default 1) when `cs_wm[prev_cs]` is 1. Otherwise G2 is the value of the 2-bit field `cs_tim_cfg[prev_cs*6 + k*2 +: 2]` taken directly as a cycle count. k=1 after a write. After a read, k=2 when the next access uses the same chip select and k=0 when it uses another one.
- R5: G3 is the sum `rd_xfer_cyc + int_idle_cyc + wr_wait_cyc`.
- R6: G4 is the decoded `diff_mem_code` (R3 table) when `prev_mtype` differs from `next_mtype`, and 0 otherwise.
- R7: In the cycle after an `acc_done` that loads a count N, `idle_left` equals N. It then falls by one each cycle until it reaches 0 and stays at 0. `ready` is high exactly when `idle_left` is 0.
- R8: `grant` equals `next_req` while `ready` is high and is 0 otherwise. A request that arrives after the count has run out is granted in the same cycle.
- R9: An `acc_done` that arrives while a count is running replaces the remaining count with the newly computed one.
- R10: A synchronous `rst` clears `idle_left` to 0 and drives `ready` high, even in the middle of a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_done | input | 1 | Previous access has ended; the idle count is loaded in this cycle |
| prev_wr | input | 1 | Previous access was a write |
| prev_cs | input | CSW | Chip select of the previous access |
| prev_mtype | input | MTW | Memory type of the previous access |
| next_req | input | 1 | Next access is pending |
| next_wr | input | 1 | Next access is a write |
| next_cs | input | CSW | Chip select of the next access |
| next_mtype | input | MTW | Memory type of the next access |
| next_dma | input | 1 | Next access is a DMA transfer; selects the common idle code |
| dma_idle_code | input | 3 | Common DMA idle code |
| cs_idle_cfg | input | NCS*15 | Five 3-bit transition idle codes for each chip select |
| cs_tim_cfg | input | NCS*6 | Three 2-bit timing waits for each chip select |
| cs_wm | input | NCS | Wait-mode bit for each chip select |
| rd_xfer_cyc | input | XW | Read data return cycles |
| int_idle_cyc | input | XW | Internal bus idle cycles |
| wr_wait_cyc | input | XW | Write data wait cycles |
| diff_mem_code | input | 3 | Idle code applied on a memory type change |
| ready | output | 1 | No idle cycles remain |
| grant | output | 1 | Next access may start |
| idle_left | output | XW+2 | Idle cycles still to run |

## Verification
The bench sweeps every combination of direction, chip-select relation and DMA flag, with random field contents, so it would catch a design that reads the wrong transition field or the field of the wrong chip select. A second sweep sets G1 to zero and isolates the wait group. This exposes a design that ignores the wait-mode override or picks the wrong timing field. A third sweep mixes all groups, so a design that adds the groups instead of taking the maximum, drops a term of the sum, or charges the memory-type penalty when the types match would load the wrong count. Directed cases show whether a second completion in the middle of a count restarts the countdown, whether reset in the middle of a count clears it, and whether a request made after the count has run out is granted at once instead of one cycle late.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  localparam int FLD_W  = 3;
  localparam int NFLD   = 5;
  localparam int TFLD_W = 2;
  localparam int NTFLD  = 3;

  // Field index inside the per-chip-select idle setting.
  typedef enum logic [2:0] {
    TR_WR_ANY      = 3'd0,
    TR_RD_WR_OTHER = 3'd1,
    TR_RD_WR_SAME  = 3'd2,
    TR_RD_RD_OTHER = 3'd3,
    TR_RD_RD_SAME  = 3'd4
  } trans_e;

  // Field index inside the per-chip-select timing setting.
  typedef enum logic [1:0] {
    TM_PRECHARGE = 2'd0,
    TM_RECOVERY  = 2'd1,
    TM_ROWCYCLE  = 2'd2
  } tim_e;

  function automatic logic [3:0] dec3(input logic [2:0] code);
    logic [3:0] r;
    case (code)
      3'd0: r = 4'd0;
      3'd1: r = 4'd1;
      3'd2: r = 4'd2;
      3'd3: r = 4'd3;
      3'd4: r = 4'd4;
      3'd5: r = 4'd6;
      3'd6: r = 4'd8;
      default: r = 4'd10;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] dec2(input logic [1:0] code);
    return {2'b00, code};
  endfunction

  function automatic trans_e classify(input logic pwr, input logic nwr,
                                      input logic same);
    trans_e t;
    if (pwr)              t = TR_WR_ANY;
    else if (nwr && same) t = TR_RD_WR_SAME;
    else if (nwr)         t = TR_RD_WR_OTHER;
    else if (same)        t = TR_RD_RD_SAME;
    else                  t = TR_RD_RD_OTHER;
    return t;
  endfunction

  function automatic tim_e tim_pick(input logic pwr, input logic same);
    tim_e t;
    if (pwr)       t = TM_RECOVERY;
    else if (same) t = TM_ROWCYCLE;
    else           t = TM_PRECHARGE;
    return t;
  endfunction

endpackage

// File: rtl/idle_grp_sel.sv
module idle_grp_sel
  import idle_gap_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int CW      = 6,
  parameter int WM_IDLE = 1,
  localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CFGW   = NFLD * FLD_W,
  localparam int TCFGW  = NTFLD * TFLD_W
) (
  input  logic                 prev_wr,
  input  logic [CSW-1:0]       prev_cs,
  input  logic                 next_wr,
  input  logic [CSW-1:0]       next_cs,
  input  logic                 next_dma,
  input  logic [2:0]           dma_idle_code,
  input  logic [NCS*CFGW-1:0]  cs_idle_cfg,
  input  logic [NCS*TCFGW-1:0] cs_tim_cfg,
  input  logic [NCS-1:0]       cs_wm,
  output logic [CW-1:0]        g1,
  output logic [CW-1:0]        g2
);

  logic           same_cs;
  trans_e         kind;
  tim_e           tkind;
  logic [CFGW-1:0]  my_idle;
  logic [TCFGW-1:0] my_tim;
  logic [2:0]     idle_code;
  logic [1:0]     tim_code;

  assign same_cs = (prev_cs == next_cs);
  assign kind    = classify(prev_wr, next_wr, same_cs);
  assign tkind   = tim_pick(prev_wr, same_cs);

  assign my_idle   = cs_idle_cfg[int'(prev_cs)*CFGW +: CFGW];
  assign my_tim    = cs_tim_cfg[int'(prev_cs)*TCFGW +: TCFGW];
  assign idle_code = my_idle[int'(kind)*FLD_W +: FLD_W];
  assign tim_code  = my_tim[int'(tkind)*TFLD_W +: TFLD_W];

  always_comb begin
    if (next_dma) g1 = CW'(dec3(dma_idle_code));
    else          g1 = CW'(dec3(idle_code));
  end

  always_comb begin
    if (cs_wm[prev_cs]) g2 = CW'(WM_IDLE);
    else                g2 = CW'(dec2(tim_code));
  end

endmodule

// File: rtl/idle_gap_max.sv
module idle_gap_max
  import idle_gap_pkg::*;
#(
  parameter int XW  = 4,
  parameter int MTW = 2,
  localparam int CW = XW + 2
) (
  input  logic [CW-1:0]  g1,
  input  logic [CW-1:0]  g2,
  input  logic [XW-1:0]  rd_xfer_cyc,
  input  logic [XW-1:0]  int_idle_cyc,
  input  logic [XW-1:0]  wr_wait_cyc,
  input  logic [MTW-1:0] prev_mtype,
  input  logic [MTW-1:0] next_mtype,
  input  logic [2:0]     diff_mem_code,
  output logic [CW-1:0]  g3,
  output logic [CW-1:0]  g4,
  output logic [CW-1:0]  gap
);

  logic [CW-1:0] m12, m34;

  assign g3 = CW'(rd_xfer_cyc) + CW'(int_idle_cyc) + CW'(wr_wait_cyc);
  assign g4 = (prev_mtype != next_mtype) ? CW'(dec3(diff_mem_code)) : '0;

  assign m12 = (g1 > g2) ? g1 : g2;
  assign m34 = (g3 > g4) ? g3 : g4;
  assign gap = (m12 > m34) ? m12 : m34;

endmodule

// File: rtl/idle_gap_timer.sv
module idle_gap_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] gap,
  input  logic          next_req,
  output logic          ready,
  output logic          grant,
  output logic [CW-1:0] idle_left
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= gap;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign idle_left = cnt;
  assign ready     = (cnt == '0);
  assign grant     = ready & next_req;

endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
  import idle_gap_pkg::*;
#(
  parameter int NCS     = 4,
  parameter int MTW     = 2,
  parameter int XW      = 4,
  parameter int WM_IDLE = 1,
  localparam int CSW    = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int CW     = XW + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        acc_done,
  input  logic                        prev_wr,
  input  logic [CSW-1:0]              prev_cs,
  input  logic [MTW-1:0]              prev_mtype,
  input  logic                        next_req,
  input  logic                        next_wr,
  input  logic [CSW-1:0]              next_cs,
  input  logic [MTW-1:0]              next_mtype,
  input  logic                        next_dma,
  input  logic [2:0]                  dma_idle_code,
  input  logic [NCS*NFLD*FLD_W-1:0]   cs_idle_cfg,
  input  logic [NCS*NTFLD*TFLD_W-1:0] cs_tim_cfg,
  input  logic [NCS-1:0]              cs_wm,
  input  logic [XW-1:0]               rd_xfer_cyc,
  input  logic [XW-1:0]               int_idle_cyc,
  input  logic [XW-1:0]               wr_wait_cyc,
  input  logic [2:0]                  diff_mem_code,
  output logic                        ready,
  output logic                        grant,
  output logic [CW-1:0]               idle_left
);

  logic [CW-1:0] g1_w, g2_w, g3_w, g4_w, gap_w;

  idle_grp_sel #(.NCS(NCS), .CW(CW), .WM_IDLE(WM_IDLE)) u_sel (
    .prev_wr       (prev_wr),
    .prev_cs       (prev_cs),
    .next_wr       (next_wr),
    .next_cs       (next_cs),
    .next_dma      (next_dma),
    .dma_idle_code (dma_idle_code),
    .cs_idle_cfg   (cs_idle_cfg),
    .cs_tim_cfg    (cs_tim_cfg),
    .cs_wm         (cs_wm),
    .g1            (g1_w),
    .g2            (g2_w)
  );

  idle_gap_max #(.XW(XW), .MTW(MTW)) u_max (
    .g1            (g1_w),
    .g2            (g2_w),
    .rd_xfer_cyc   (rd_xfer_cyc),
    .int_idle_cyc  (int_idle_cyc),
    .wr_wait_cyc   (wr_wait_cyc),
    .prev_mtype    (prev_mtype),
    .next_mtype    (next_mtype),
    .diff_mem_code (diff_mem_code),
    .g3            (g3_w),
    .g4            (g4_w),
    .gap           (gap_w)
  );

  idle_gap_timer #(.CW(CW)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .load      (acc_done),
    .gap       (gap_w),
    .next_req  (next_req),
    .ready     (ready),
    .grant     (grant),
    .idle_left (idle_left)
  );

endmodule

// File: rtl/idle_gap_checker.sv
module idle_gap_checker #(
  parameter int MTW = 2,
  parameter int CW  = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           acc_done,
  input logic [MTW-1:0] prev_mtype,
  input logic [MTW-1:0] next_mtype,
  input logic           ready,
  input logic           grant,
  input logic [CW-1:0]  idle_left,
  input logic [CW-1:0]  g1,
  input logic [CW-1:0]  g2,
  input logic [CW-1:0]  g3,
  input logic [CW-1:0]  g4,
  input logic [CW-1:0]  gap
);

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> idle_left == $past(gap));

  a_r1_max_bound: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> (gap >= g1) && (gap >= g2) && (gap >= g3) && (gap >= g4));

  a_r1_max_pick: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> (gap == g1) || (gap == g2) || (gap == g3) || (gap == g4));

  a_r6_same_type: assert property (@(posedge clk) disable iff (rst)
    (prev_mtype == next_mtype) |-> g4 == '0);

  a_r7_countdown: assert property (@(posedge clk) disable iff (rst)
    (!acc_done && idle_left != '0) |=> idle_left == CW'($past(idle_left) - 1'b1));

  a_r7_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (!acc_done && idle_left == '0) |=> idle_left == '0);

  a_r8_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    (idle_left != '0) |-> !grant && !ready);

  a_r10_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ready && idle_left == '0);

endmodule

bind bus_idle_gap idle_gap_checker #(.MTW(MTW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_done   (acc_done),
  .prev_mtype (prev_mtype),
  .next_mtype (next_mtype),
  .ready      (ready),
  .grant      (grant),
  .idle_left  (idle_left),
  .g1         (g1_w),
  .g2         (g2_w),
  .g3         (g3_w),
  .g4         (g4_w),
  .gap        (gap_w)
);

// File: tb/bus_idle_gap_bench.sv
module bus_idle_gap_bench;

  localparam int NCS = 4;
  localparam int MTW = 2;
  localparam int XW  = 4;
  localparam int CSW = 2;
  localparam int CW  = XW + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_done = 1'b0;
  logic prev_wr = 1'b0, next_wr = 1'b0, next_req = 1'b0, next_dma = 1'b0;
  logic [CSW-1:0] prev_cs = '0, next_cs = '0;
  logic [MTW-1:0] prev_mtype = '0, next_mtype = '0;
  logic [2:0] dma_idle_code = '0, diff_mem_code = '0;
  logic [NCS*15-1:0] cs_idle_cfg = '0;
  logic [NCS*6-1:0]  cs_tim_cfg = '0;
  logic [NCS-1:0]    cs_wm = '0;
  logic [XW-1:0] rd_xfer_cyc = '0, int_idle_cyc = '0, wr_wait_cyc = '0;
  logic ready, grant;
  logic [CW-1:0] idle_left;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_idle_gap u_bus_idle_gap (
    .clk(clk), .rst(rst), .acc_done(acc_done),
    .prev_wr(prev_wr), .prev_cs(prev_cs), .prev_mtype(prev_mtype),
    .next_req(next_req), .next_wr(next_wr), .next_cs(next_cs),
    .next_mtype(next_mtype), .next_dma(next_dma),
    .dma_idle_code(dma_idle_code), .cs_idle_cfg(cs_idle_cfg),
    .cs_tim_cfg(cs_tim_cfg), .cs_wm(cs_wm),
    .rd_xfer_cyc(rd_xfer_cyc), .int_idle_cyc(int_idle_cyc),
    .wr_wait_cyc(wr_wait_cyc), .diff_mem_code(diff_mem_code),
    .ready(ready), .grant(grant), .idle_left(idle_left)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3 table restated arithmetically
  function automatic int d3(input int c);
    return (c < 5) ? c : 2 * c - 4;
  endfunction

  function automatic int exp_gap();
    int f, k, g1, g2, g3, g4, m;
    bit same;
    same = (prev_cs == next_cs);
    if (prev_wr) f = 0;
    else if (next_wr) f = same ? 2 : 1;
    else f = same ? 4 : 3;
    if (prev_wr) k = 1;
    else k = same ? 2 : 0;
    g1 = next_dma ? d3(int'(dma_idle_code))
                  : d3(int'(cs_idle_cfg[int'(prev_cs)*15 + f*3 +: 3]));
    g2 = cs_wm[prev_cs] ? 1 : int'(cs_tim_cfg[int'(prev_cs)*6 + k*2 +: 2]);
    g3 = int'(rd_xfer_cyc) + int'(int_idle_cyc) + int'(wr_wait_cyc);
    g4 = (prev_mtype != next_mtype) ? d3(int'(diff_mem_code)) : 0;
    m = g1;
    if (g2 > m) m = g2;
    if (g3 > m) m = g3;
    if (g4 > m) m = g4;
    return m;
  endfunction

  // Called at a negedge with inputs set; pulses acc_done and follows the countdown.
  task automatic run_trans(input string req);
    int e;
    e = exp_gap();
    next_req = 1'b1;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    for (int i = 0; i <= e; i++) begin
      chk({req, " R7 idle_left"}, int'(idle_left), e - i);
      chk("R7 ready", int'(ready), (i == e) ? 1 : 0);
      chk("R8 grant", int'(grant), (i == e) ? 1 : 0);
      if (i < e) @(negedge clk);
    end
    next_req = 1'b0;
    @(negedge clk);
    chk("R8 no request no grant", int'(grant), 0);
    next_req = 1'b1;
    #1;
    chk("R8 late request granted at once", int'(grant), 1);
    next_req = 1'b0;
  endtask

  task automatic rand_cfg();
    cs_idle_cfg   = {$urandom, $urandom};
    cs_tim_cfg    = CW'(0) | 24'($urandom);
    cs_wm         = 4'($urandom);
    dma_idle_code = 3'($urandom);
    diff_mem_code = 3'($urandom);
  endtask

  task automatic zero_others();
    rd_xfer_cyc = '0; int_idle_cyc = '0; wr_wait_cyc = '0;
    cs_tim_cfg = '0; cs_wm = '0;
    next_mtype = prev_mtype;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R10 reset idle_left", int'(idle_left), 0);
    chk("R10 reset ready", int'(ready), 1);

    // R2 / R3: all transitions and both group-1 sources, other groups zero
    for (int rep = 0; rep < 4; rep++)
      for (int t = 0; t < 64; t++) begin
        rand_cfg();
        zero_others();
        prev_wr  = t[0];
        next_wr  = t[1];
        next_dma = t[2];
        prev_cs  = t[4:3];
        next_cs  = t[5:4] ^ CSW'(rep);
        run_trans("R2");
      end

    // R3: every code of the common setting
    for (int c = 0; c < 8; c++) begin
      zero_others();
      next_dma = 1'b1;
      dma_idle_code = 3'(c);
      run_trans("R3");
    end

    // R4: group 1 zero, wait group isolated
    for (int t = 0; t < 96; t++) begin
      rand_cfg();
      cs_idle_cfg = '0; dma_idle_code = '0;
      rd_xfer_cyc = '0; int_idle_cyc = '0; wr_wait_cyc = '0;
      next_mtype = prev_mtype;
      prev_wr = 1'($urandom); next_wr = 1'($urandom);
      next_dma = 1'($urandom);
      prev_cs = 2'($urandom); next_cs = 2'($urandom);
      run_trans("R4");
    end

    // R5 / R6: sum group and memory-type group, plus the full mix for R1
    for (int t = 0; t < 240; t++) begin
      rand_cfg();
      if (t < 60) begin cs_idle_cfg = '0; dma_idle_code = '0; cs_wm = '0; cs_tim_cfg = '0; end
      prev_wr = 1'($urandom); next_wr = 1'($urandom);
      next_dma = 1'($urandom);
      prev_cs = 2'($urandom); next_cs = 2'($urandom);
      rd_xfer_cyc = 4'($urandom); int_idle_cyc = 4'($urandom);
      wr_wait_cyc = 4'($urandom);
      if (t % 3 == 0) begin rd_xfer_cyc = '0; int_idle_cyc = '0; wr_wait_cyc = '0; end
      prev_mtype = 2'($urandom); next_mtype = 2'($urandom);
      run_trans((t < 60) ? "R5 R6" : "R1");
    end

    // R6: same memory type, large penalty code must have no effect
    zero_others();
    cs_idle_cfg = '0; next_dma = 1'b0;
    prev_mtype = 2'd2; next_mtype = 2'd2; diff_mem_code = 3'd7;
    run_trans("R6 same type");

    // R9: second completion mid-count replaces the count
    zero_others();
    cs_idle_cfg = '0; next_dma = 1'b0;
    rd_xfer_cyc = 4'd15; int_idle_cyc = 4'd15; wr_wait_cyc = 4'd15;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    chk("R5 max sum", int'(idle_left), 45);
    repeat (3) @(negedge clk);
    chk("R7 mid count", int'(idle_left), 42);
    rd_xfer_cyc = 4'd2; int_idle_cyc = 4'd3; wr_wait_cyc = 4'd0;
    run_trans("R9 reload");

    // R10: reset in the middle of a count
    rd_xfer_cyc = 4'd15; int_idle_cyc = 4'd15; wr_wait_cyc = 4'd15;
    acc_done = 1'b1;
    @(negedge clk);
    acc_done = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 count running", int'(ready), 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 mid reset idle_left", int'(idle_left), 0);
    chk("R10 mid reset ready", int'(ready), 1);
    @(negedge clk);
    chk("R10 stays idle", int'(idle_left), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule